// File: doc/BRIEF.md
# Prescaled Watchdog Timer Channel

This block is a single watchdog channel. Software programs it through a plain register port: a control word with four enables, a 10-bit prescale ratio, a 32-bit reload value and a 32-bit warning threshold. It can also read back the live count. A prescaler turns the clock into decrement ticks for a 32-bit down counter. When the count matches the threshold, the channel raises a warning. When the count is exhausted, the channel stops, raises a timeout interrupt and requests a subsystem reset.

Writing the reload value does three things in one cycle: it restarts the count, it restarts the prescaler, and it captures the prescale ratio currently held in its register. This is how software refreshes the watchdog. A debug-acknowledge input pauses both the counter and the prescaler for as long as it is high.

The register port carries no stream traffic, so it has no valid/ready handshake. Every write and every read request is accepted in the cycle it is presented, and the port never applies back-pressure. Each read request produces exactly one response, one cycle later.

Top module: `wdt_channel`

## Requirements
- R1: After reset, every register reads zero, and the warning, timeout and reset-request outputs are low.
- R2: Register offsets are 0x00 control, 0x04 prescale, 0x08 reload, 0x0C live count (read-only) and 0x10 warning threshold. Any other offset reads zero. Control bits are: bit 0 run, bit 1 timeout-interrupt enable, bit 2 warning enable, bit 3 reset-request enable. Bits 31:4 of the control word read zero. Read data and `reg_rvalid` appear one cycle after `reg_rd`. At all other times the read data is zero.
- R3: A write to the reload offset sets the live count to the written value on the next edge. In the same cycle it restarts the prescaler from the stored prescale ratio and clears any warning or timeout state.
- R4: While running, the count falls by one every (prescale+1) cycles. With run set continuously, the timeout output rises exactly (prescale+1)×(reload+1) cycles after the edge that starts counting.
- R5: Once the count is zero, the next tick enters the timeout state. The count then stays at zero until the next reload write.
- R6: The timeout interrupt equals the timeout state gated by control bit 1. The reset request equals the timeout state gated by control bit 3. Both are levels that persist until a reload write or until run is cleared.
- R7: The warning output rises one cycle after the live count equals the threshold while run is set, provided control bit 2 is set. It then holds until a reload write or until run is cleared.
- R8: While `dbg_ack` is high, the count and the prescaler are frozen. Each cycle of debug therefore delays the timeout by one cycle.
- R9: Clearing run freezes the count and drops the warning and timeout state on the next edge.
- R10: A prescale write alone leaves the period in progress unchanged. The new ratio takes effect only at the next reload write.
- R11: A write to the live-count offset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read request |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| reg_rvalid | output | 1 | Read data valid |
| dbg_ack | input | 1 | Debug acknowledge; pauses counting |
| irq_warn | output | 1 | Warning interrupt level |
| irq_timeout | output | 1 | Timeout interrupt level |
| rst_req | output | 1 | Subsystem reset request level |

## Verification
Read data arrives one edge after the request. A reload takes effect on the edge that captures the write. The warning rises one edge after the count equals the threshold. The timeout rises (prescale+1)×(reload+1) edges after counting starts, plus one edge for every cycle spent in debug.

The bench drives all inputs on falling edges and advances a behavioural model on rising edges. On every falling edge it compares the outputs and read data with the model, so each result is checked in the exact cycle it is due. Directed checks count falling edges from the stimulus to the first high output and compare that count with the closed-form latency.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_CTRL  = 'h00;
  localparam int ADDR_PSC   = 'h04;
  localparam int ADDR_LOAD  = 'h08;
  localparam int ADDR_COUNT = 'h0C;
  localparam int ADDR_WARN  = 'h10;
  localparam int CTRL_W     = 4;

  typedef struct packed {
    logic rst_en;
    logic warn_en;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 10,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count_i,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output ctrl_t         ctrl_o,
  output logic [PW-1:0] psc_o,
  output logic [DW-1:0] warn_o,
  output logic          load_o
);
  localparam int CTRL_PAD = DW - CTRL_W;
  localparam int PSC_PAD  = DW - PW;

  ctrl_t         ctrl_q;
  logic [PW-1:0] psc_q;
  logic [DW-1:0] load_q;
  logic [DW-1:0] warn_q;
  logic [DW-1:0] rd_mux;

  assign load_o = wr_en && (addr == AW'(ADDR_LOAD));
  assign ctrl_o = ctrl_q;
  assign psc_o  = psc_q;
  assign warn_o = warn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      load_q <= '0;
      warn_q <= '0;
    end else if (wr_en) begin
      case (addr)
        AW'(ADDR_CTRL): ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        AW'(ADDR_PSC):  psc_q  <= wdata[PW-1:0];
        AW'(ADDR_LOAD): load_q <= wdata;
        AW'(ADDR_WARN): warn_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      AW'(ADDR_CTRL):  rd_mux = {{CTRL_PAD{1'b0}}, ctrl_q};
      AW'(ADDR_PSC):   rd_mux = {{PSC_PAD{1'b0}}, psc_q};
      AW'(ADDR_LOAD):  rd_mux = load_q;
      AW'(ADDR_COUNT): rd_mux = count_i;
      AW'(ADDR_WARN):  rd_mux = warn_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd_en ? rd_mux : '0;
      rvalid <= rd_en;
    end
  end

  assert_rvalid_follows_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_rdata_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rvalid && rdata == '0));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] psc_i,
  input  logic          run_i,
  output logic          tick_o
);
  logic [PW-1:0] lat_q;
  logic [PW-1:0] cnt_q;

  assign tick_o = run_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      lat_q <= psc_i;
      cnt_q <= psc_i;
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? lat_q : cnt_q - 1'b1;
    end
  end

  assert_ratio_only_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(lat_q));
  assert_psc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          enable_i,
  input  logic          dbg_i,
  input  logic          tick_i,
  input  logic [DW-1:0] warn_val_i,
  output logic          run_o,
  output logic [DW-1:0] count_o,
  output logic          tmo_o,
  output logic          warn_o
);
  logic [DW-1:0] cnt_q;
  logic          tmo_q;
  logic          wrn_q;

  assign run_o   = enable_i && !dbg_i && !tmo_q;
  assign count_o = cnt_q;
  assign tmo_o   = tmo_q;
  assign warn_o  = wrn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
      wrn_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      tmo_q <= 1'b0;
      wrn_q <= 1'b0;
    end else if (!enable_i) begin
      tmo_q <= 1'b0;
      wrn_q <= 1'b0;
    end else begin
      if (cnt_q == warn_val_i) wrn_q <= 1'b1;
      if (tick_i) begin
        if (cnt_q == '0) tmo_q <= 1'b1;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i) && !tmo_q && !wrn_q));
  assert_dbg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && !load_i) |=> $stable(cnt_q));
  assert_disable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !load_i) |=> ($stable(cnt_q) && !tmo_q && !wrn_q));
  assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !load_i) |=> (cnt_q == '0));
  assert_timeout_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> (cnt_q == '0));
endmodule

// File: rtl/wdt_channel.sv
module wdt_channel
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 10,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  input  logic          dbg_ack,
  output logic          irq_warn,
  output logic          irq_timeout,
  output logic          rst_req
);
  ctrl_t         ctrl;
  logic [PW-1:0] psc;
  logic [DW-1:0] warn_val;
  logic [DW-1:0] count;
  logic          load;
  logic          run;
  logic          tick;
  logic          tmo;
  logic          wrn;

  wdt_regfile #(.DW(DW), .PW(PW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .count_i (count),
    .rdata   (reg_rdata),
    .rvalid  (reg_rvalid),
    .ctrl_o  (ctrl),
    .psc_o   (psc),
    .warn_o  (warn_val),
    .load_o  (load)
  );

  wdt_prescaler #(.PW(PW)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .psc_i  (psc),
    .run_i  (run),
    .tick_o (tick)
  );

  wdt_core #(.DW(DW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (reg_wdata),
    .enable_i   (ctrl.run),
    .dbg_i      (dbg_ack),
    .tick_i     (tick),
    .warn_val_i (warn_val),
    .run_o      (run),
    .count_o    (count),
    .tmo_o      (tmo),
    .warn_o     (wrn)
  );

  assign irq_warn    = wrn && ctrl.warn_en;
  assign irq_timeout = tmo && ctrl.irq_en;
  assign rst_req     = tmo && ctrl.rst_en;

  assert_outputs_clear_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !load) |=> (!irq_warn && !irq_timeout && !rst_req));
  assert_reload_clears_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!irq_timeout && !rst_req && !irq_warn));
endmodule

// File: tb/wdt_channel_bench.sv
module wdt_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        dbg_ack = 1'b0;
  logic        irq_warn;
  logic        irq_timeout;
  logic        rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdt_channel u_wdt_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .dbg_ack(dbg_ack), .irq_warn(irq_warn),
    .irq_timeout(irq_timeout), .rst_req(rst_req)
  );

  // behavioural reference state
  logic [31:0] m_ctrl, m_psc, m_load, m_warn, m_cnt, m_plat, m_pcnt, m_rdata;
  logic        m_tmo, m_wrn, m_rv;

  function automatic logic [31:0] m_lookup(input logic [4:0] a);
    case (a)
      5'h00:   return m_ctrl;
      5'h04:   return m_psc;
      5'h08:   return m_load;
      5'h0C:   return m_cnt;
      5'h10:   return m_warn;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_psc = 0; m_load = 0; m_warn = 0; m_cnt = 0;
      m_plat = 0; m_pcnt = 0; m_rdata = 0; m_tmo = 0; m_wrn = 0; m_rv = 0;
    end else begin
      logic [31:0] o_ctrl, o_psc, o_warn, o_cnt;
      logic        o_tmo, running;
      o_ctrl = m_ctrl; o_psc = m_psc; o_warn = m_warn; o_cnt = m_cnt; o_tmo = m_tmo;
      running = o_ctrl[0] && !dbg_ack && !o_tmo;
      m_rv = reg_rd;
      m_rdata = reg_rd ? m_lookup(reg_addr) : 32'h0;
      if (reg_wr) begin
        if (reg_addr == 5'h00) m_ctrl = {28'h0, reg_wdata[3:0]};
        if (reg_addr == 5'h04) m_psc  = {22'h0, reg_wdata[9:0]};
        if (reg_addr == 5'h08) m_load = reg_wdata;
        if (reg_addr == 5'h10) m_warn = reg_wdata;
      end
      if (reg_wr && reg_addr == 5'h08) begin
        m_cnt = reg_wdata; m_plat = o_psc; m_pcnt = o_psc; m_tmo = 0; m_wrn = 0;
      end else if (!o_ctrl[0]) begin
        m_tmo = 0; m_wrn = 0;
      end else begin
        if (o_cnt == o_warn) m_wrn = 1;
        if (running) begin
          if (m_pcnt == 0) begin
            m_pcnt = m_plat;
            if (o_cnt == 0) m_tmo = 1;
            else m_cnt = o_cnt - 1;
          end else begin
            m_pcnt = m_pcnt - 1;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(irq_warn === (m_wrn && m_ctrl[2]), "R7 irq_warn vs model",
            {31'h0, irq_warn}, {31'h0, m_wrn && m_ctrl[2]});
      check(irq_timeout === (m_tmo && m_ctrl[1]), "R6 irq_timeout vs model",
            {31'h0, irq_timeout}, {31'h0, m_tmo && m_ctrl[1]});
      check(rst_req === (m_tmo && m_ctrl[3]), "R6 rst_req vs model",
            {31'h0, rst_req}, {31'h0, m_tmo && m_ctrl[3]});
      check(reg_rvalid === m_rv && reg_rdata === m_rdata, "R2 read port vs model",
            reg_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rvalid === 1'b1 && reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_timeout(input int start, output int n, output int warn_at);
    n = start; warn_at = -1;
    while (!irq_timeout && n < 5000) begin
      @(negedge clk);
      n++;
      if (irq_warn && warn_at < 0) warn_at = n;
    end
  endtask

  initial begin
    int n, wa;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!irq_warn && !irq_timeout && !rst_req, "R1 outputs low after reset",
          {29'h0, irq_warn, irq_timeout, rst_req}, 32'h0);
    rd(5'h00, 32'h0, "R1 control reset");
    rd(5'h04, 32'h0, "R1 prescale reset");
    rd(5'h08, 32'h0, "R1 reload reset");
    rd(5'h0C, 32'h0, "R1 count reset");
    rd(5'h10, 32'h0, "R1 threshold reset");
    // R2: control width, unmapped offset; unloaded enable fires at once
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, 32'h0000_000F, "R2 control upper bits read zero");
    check(irq_timeout && rst_req && irq_warn, "R6 unloaded enable asserts outputs",
          {29'h0, irq_warn, irq_timeout, rst_req}, 32'h7);
    rd(5'h14, 32'h0, "R2 unmapped offset reads zero");
    wr(5'h00, 32'h0);
    check(!irq_timeout && !rst_req && !irq_warn, "R9 disable drops outputs",
          {29'h0, irq_warn, irq_timeout, rst_req}, 32'h0);
    // R3/R4/R7: programmed run, prescale 2, reload 6, threshold 3
    wr(5'h10, 32'd3);
    wr(5'h04, 32'd2);
    wr(5'h08, 32'd6);
    rd(5'h08, 32'd6, "R3 reload reads back");
    rd(5'h0C, 32'd6, "R3 count takes reload");
    wr(5'h00, 32'hF);
    wait_timeout(0, n, wa);
    check(n == 21, "R4 timeout latency (P+1)(N+1)", n, 21);
    check(wa == 10, "R7 warning latency", wa, 10);
    rd(5'h0C, 32'd0, "R5 count at zero in timeout");
    repeat (5) @(negedge clk);
    check(irq_timeout && rst_req, "R6 timeout level persists",
          {30'h0, irq_timeout, rst_req}, 32'h3);
    rd(5'h0C, 32'd0, "R5 count stays zero");
    // R8: debug pause, prescale 1, reload 5 while running
    wr(5'h04, 32'd1);
    wr(5'h08, 32'd5);
    check(!irq_timeout && !irq_warn, "R3 reload clears timeout and warning",
          {30'h0, irq_warn, irq_timeout}, 32'h0);
    repeat (3) @(negedge clk);
    dbg_ack = 1'b1;
    repeat (10) @(negedge clk);
    dbg_ack = 1'b0;
    wait_timeout(13, n, wa);
    check(n == 22, "R8 debug delays timeout", n, 22);
    // R10: prescale change mid-period has no effect until reload
    wr(5'h00, 32'h0);
    wr(5'h04, 32'd3);
    wr(5'h08, 32'd2);
    wr(5'h00, 32'hB);
    wr(5'h04, 32'd0);
    wait_timeout(1, n, wa);
    check(n == 12, "R10 latched prescale kept", n, 12);
    // R11: live count not writable
    wr(5'h00, 32'h0);
    wr(5'h08, 32'd9);
    wr(5'h0C, 32'h55);
    rd(5'h0C, 32'd9, "R11 count write ignored");
    // R9: disable freezes count
    wr(5'h00, 32'h1);
    repeat (4) @(negedge clk);
    wr(5'h00, 32'h0);
    held = m_cnt;
    rd(5'h0C, held, "R9 count frozen after disable");
    repeat (5) @(negedge clk);
    rd(5'h0C, held, "R9 count still frozen");
    check(held < 32'd9, "R4 count moved while running", held, 32'd8);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", WD_LIMIT, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule